// File: doc/BRIEF.md
# Teletext Display Row Mapper

This block turns a raster position into a character-memory fetch request. Each cycle it receives a display row slot (0 to 24) and a scan line within that slot (0 to 9). One clock later it returns four things: which memory to read (basic page or extension packet), the source row, the glyph scan line to use, and a visibility flag. Blanked positions carry all-zero fetch fields.

The block has five configuration bits. Whole-page enlargement draws each source row across two slots. A half select picks the upper half (rows 0 to 11) or the lower half (rows 12 to 24) of the page for enlargement. A status-only mode blanks everything except the last slot. A row-24 redirect fetches the last row from row 0 of the extension memory. A page-level link flag cancels that redirect. The configuration bits are captured only on a start-of-field strobe, so a field is never drawn with mixed settings.

A live per-row vector marks source rows that hold double-height characters. Such a row is stretched over its own slot and the following slot, and the following row's own content is not fetched. Under enlargement this stretch becomes four times the normal height.

Top module: `tt_row_mapper`

## Requirements
- R1: All outputs come from registers and reflect the inputs presented one clock earlier. While rst_ni is low, vis_o, mem_ext_o, src_row_o and src_line_o are all 0.
- R2: The five configuration inputs take effect only from the cycle after field_start_i is high. Changing them at any other time leaves the mapping unchanged.
- R3: With enlargement off and no double-height rows, slot r and line l map to src_row_o = r and src_line_o = l, with vis_o = 1 and mem_ext_o = 0.
- R4: With enlargement off, a row r (r < 24) whose row_dh_i bit is set maps its own slot to src_line_o = l/2. Slot r+1 then maps to source row r with src_line_o = (10+l)/2. A row consumed this way does not itself start a span. Row 24 never starts a span, and row 23 never spills into slot 24.
- R5: With enlargement on and bottom_sel_i = 0, slot d maps to source row d/2 with src_line_o = (10*(d mod 2)+l)/2. Slot 24, whose source row would be 12, is invisible.
- R6: With enlargement on and bottom_sel_i = 1, slot d maps to source row 12 + d/2 with the same line rule as R5. Slot 24 therefore shows the upper half of row 24.
- R7: With enlargement on, let y = 10*(d mod 2)+l. A double-height source row s gives src_line_o = y/4. The row after it shows row s with src_line_o = (y+20)/4, but only when s lies inside the enlarged half. Otherwise that row is drawn as a plain enlarged row.
- R8: With status-only set, every slot below 24 gives vis_o = 0.
- R9: With the row-24 redirect set and the link flag clear, a visible fetch of source row 24 gives mem_ext_o = 1 (1 selects the extension memory) and src_row_o = 0.
- R10: With the link flag set, mem_ext_o stays 0 and source row 24 is fetched from the basic page.
- R11: A slot above 24 or a scan line above 9 gives vis_o = 0 with all other outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| field_start_i | input | 1 | Start-of-field strobe; captures the configuration |
| dbl_mode_i | input | 1 | Whole-page enlargement |
| bottom_sel_i | input | 1 | 0: enlarge rows 0-11, 1: enlarge rows 12-24 |
| status_only_i | input | 1 | Blank slots 0-23 |
| row24_ext_i | input | 1 | Take row 24 from extension memory row 0 |
| link_back_i | input | 1 | Page flag forcing row 24 back to the basic page |
| row_dh_i | input | ROWS (25) | Per source row: holds double-height characters |
| disp_row_i | input | ROW_W (5) | Display row slot |
| scan_line_i | input | LINE_W (4) | Scan line within the slot |
| vis_o | output | 1 | Position is visible |
| mem_ext_o | output | 1 | 1: extension memory, 0: basic page |
| src_row_o | output | ROW_W (5) | Source row to fetch |
| src_line_o | output | LINE_W (4) | Glyph scan line |

## Verification
The bench sweeps every slot and line, including out-of-range values, under all 32 configuration combinations and three double-height patterns. The patterns include chained double-height rows, a double-height row 23, and a double-height row 11 seen from the lower half. A design that let a consumed row start its own span would draw a row that should be hidden. A design that let row 23 spill into slot 24 would hide the prompt row. A design that used a span from outside the enlarged half would show row 11 inside the lower-half view. A separate check changes the configuration between field strobes; a design that sampled the bits live would switch mapping in the middle of a field.

// File: rtl/tt_map_pkg.sv
package tt_map_pkg;
  typedef struct packed {
    logic dbl_mode;
    logic bottom_sel;
    logic status_only;
    logic row24_ext;
    logic link_back;
  } cfg_t;
endpackage

// File: rtl/tt_cfg_latch.sv
module tt_cfg_latch
  import tt_map_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic field_start_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cfg_o <= '0;
    else if (field_start_i) cfg_o <= cfg_i;
  end
endmodule

// File: rtl/tt_span_decode.sv
module tt_span_decode #(
  parameter int ROWS = 25
) (
  input  logic [ROWS-1:0] row_dh_i,
  output logic [ROWS-1:0] upper_o,
  output logic [ROWS-1:0] cont_o
);
  // a span never starts on, nor spills into, the last row
  assign cont_o[0]  = 1'b0;
  assign upper_o[0] = row_dh_i[0];
  for (genvar g = 1; g < ROWS; g++) begin : g_span
    if (g == ROWS - 1) begin : g_last
      assign cont_o[g]  = 1'b0;
      assign upper_o[g] = 1'b0;
    end else begin : g_mid
      assign cont_o[g]  = upper_o[g-1];
      assign upper_o[g] = row_dh_i[g] & ~cont_o[g];
    end
  end
endmodule

// File: rtl/tt_row_map.sv
module tt_row_map
  import tt_map_pkg::*;
#(
  parameter int ROWS   = 25,
  parameter int LINES  = 10,
  parameter int ROW_W  = $clog2(ROWS),
  parameter int LINE_W = $clog2(LINES)
) (
  input  cfg_t              cfg_i,
  input  logic [ROWS-1:0]   upper_i,
  input  logic [ROWS-1:0]   cont_i,
  input  logic [ROW_W-1:0]  disp_row_i,
  input  logic [LINE_W-1:0] scan_line_i,
  output logic              vis_o,
  output logic              ext_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [LINE_W-1:0] line_o
);
  localparam int HALF_ROWS = (ROWS - 1) / 2;

  int s, y, base, row_n, line_n;
  logic [ROW_W-1:0] idx;
  logic vis, ext;

  always_comb begin
    vis = 1'b0; ext = 1'b0;
    row_n = 0; line_n = 0; s = 0; y = 0; base = 0;
    idx = '0;
    if (int'(disp_row_i) < ROWS && int'(scan_line_i) < LINES) begin
      vis = 1'b1;
      if (!cfg_i.dbl_mode) begin
        s   = int'(disp_row_i);
        y   = int'(scan_line_i);
        idx = disp_row_i;
        if (cont_i[idx]) begin
          row_n  = s - 1;
          line_n = (y + LINES) / 2;
        end else if (upper_i[idx]) begin
          row_n  = s;
          line_n = y / 2;
        end else begin
          row_n  = s;
          line_n = y;
        end
      end else begin
        base = cfg_i.bottom_sel ? HALF_ROWS : 0;
        s    = base + int'(disp_row_i) / 2;
        y    = (disp_row_i[0] ? LINES : 0) + int'(scan_line_i);
        if (s >= ROWS || (!cfg_i.bottom_sel && s >= HALF_ROWS)) begin
          vis = 1'b0;
        end else begin
          idx = ROW_W'(s);
          if (cont_i[idx] && (s - 1) >= base) begin
            row_n  = s - 1;
            line_n = (y + 2 * LINES) / 4;
          end else if (upper_i[idx]) begin
            row_n  = s;
            line_n = y / 4;
          end else begin
            row_n  = s;
            line_n = y / 2;
          end
        end
      end
      if (cfg_i.status_only && int'(disp_row_i) < ROWS - 1) vis = 1'b0;
    end
    ext = vis && cfg_i.row24_ext && !cfg_i.link_back && row_n == ROWS - 1;
    if (ext) row_n = 0;
    if (!vis) begin
      row_n  = 0;
      line_n = 0;
    end
  end

  assign vis_o  = vis;
  assign ext_o  = ext;
  assign row_o  = ROW_W'(row_n);
  assign line_o = LINE_W'(line_n);
endmodule

// File: rtl/tt_row_mapper.sv
module tt_row_mapper
  import tt_map_pkg::*;
#(
  parameter int ROWS   = 25,
  parameter int LINES  = 10,
  parameter int ROW_W  = $clog2(ROWS),
  parameter int LINE_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              field_start_i,
  input  logic              dbl_mode_i,
  input  logic              bottom_sel_i,
  input  logic              status_only_i,
  input  logic              row24_ext_i,
  input  logic              link_back_i,
  input  logic [ROWS-1:0]   row_dh_i,
  input  logic [ROW_W-1:0]  disp_row_i,
  input  logic [LINE_W-1:0] scan_line_i,
  output logic              vis_o,
  output logic              mem_ext_o,
  output logic [ROW_W-1:0]  src_row_o,
  output logic [LINE_W-1:0] src_line_o
);
  cfg_t cfg_in, cfg_q;
  logic [ROWS-1:0] upper, cont;
  logic vis_n, ext_n;
  logic [ROW_W-1:0]  row_n;
  logic [LINE_W-1:0] line_n;

  assign cfg_in = '{dbl_mode: dbl_mode_i, bottom_sel: bottom_sel_i,
                    status_only: status_only_i, row24_ext: row24_ext_i,
                    link_back: link_back_i};

  tt_cfg_latch u_cfg (
    .clk_i, .rst_ni, .field_start_i, .cfg_i(cfg_in), .cfg_o(cfg_q)
  );

  tt_span_decode #(.ROWS(ROWS)) u_span (
    .row_dh_i, .upper_o(upper), .cont_o(cont)
  );

  tt_row_map #(.ROWS(ROWS), .LINES(LINES), .ROW_W(ROW_W), .LINE_W(LINE_W)) u_map (
    .cfg_i(cfg_q), .upper_i(upper), .cont_i(cont),
    .disp_row_i, .scan_line_i,
    .vis_o(vis_n), .ext_o(ext_n), .row_o(row_n), .line_o(line_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_o      <= 1'b0;
      mem_ext_o  <= 1'b0;
      src_row_o  <= '0;
      src_line_o <= '0;
    end else begin
      vis_o      <= vis_n;
      mem_ext_o  <= ext_n;
      src_row_o  <= row_n;
      src_line_o <= line_n;
    end
  end
endmodule

// File: rtl/tt_row_mapper_chk.sv
module tt_row_mapper_chk
  import tt_map_pkg::*;
#(
  parameter int ROWS   = 25,
  parameter int LINES  = 10,
  parameter int ROW_W  = $clog2(ROWS),
  parameter int LINE_W = $clog2(LINES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              field_start_i,
  input logic [ROW_W-1:0]  disp_row_i,
  input logic [LINE_W-1:0] scan_line_i,
  input cfg_t              cfg_q,
  input logic              vis_o,
  input logic              mem_ext_o,
  input logic [ROW_W-1:0]  src_row_o,
  input logic [LINE_W-1:0] src_line_o
);
  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(field_start_i) |-> $stable(cfg_q));

  assert_row_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vis_o |-> int'(src_row_o) < ROWS);

  assert_line_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vis_o |-> int'(src_line_o) < LINES);

  assert_top_cut_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_q.dbl_mode && !cfg_q.bottom_sel && int'(disp_row_i) == ROWS - 1) |-> !vis_o);

  assert_status_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_q.status_only && int'(disp_row_i) < ROWS - 1) |-> !vis_o);

  assert_ext_row0_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ext_o |-> vis_o && src_row_o == '0);

  assert_link_back_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_q.link_back || !cfg_q.row24_ext) |-> !mem_ext_o);

  assert_out_of_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(int'(disp_row_i) >= ROWS || int'(scan_line_i) >= LINES)
      |-> !vis_o && !mem_ext_o && src_row_o == '0 && src_line_o == '0);
endmodule

bind tt_row_mapper tt_row_mapper_chk #(
  .ROWS(ROWS), .LINES(LINES), .ROW_W(ROW_W), .LINE_W(LINE_W)
) u_chk (.*);

// File: tb/tb_tt_row_mapper.sv
module tb_tt_row_mapper;
  localparam int ROWS = 25;
  localparam int LINES = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic field_start_i = 1'b0;
  logic dbl_mode_i = 1'b0, bottom_sel_i = 1'b0, status_only_i = 1'b0;
  logic row24_ext_i = 1'b0, link_back_i = 1'b0;
  logic [24:0] row_dh_i = '0;
  logic [4:0] disp_row_i = '0;
  logic [3:0] scan_line_i = '0;
  logic vis_o, mem_ext_o;
  logic [4:0] src_row_o;
  logic [3:0] src_line_o;

  int compared = 0;
  int mismatched = 0;

  // configuration the bench believes is latched
  logic m_d = 0, m_b = 0, m_s = 0, m_e = 0, m_k = 0;
  logic pend = 0;
  logic [10:0] exp_v;
  string exp_tag;

  always #4 clk = ~clk;

  tt_row_mapper dut (
    .clk_i(clk), .rst_ni, .field_start_i, .dbl_mode_i, .bottom_sel_i,
    .status_only_i, .row24_ext_i, .link_back_i, .row_dh_i,
    .disp_row_i, .scan_line_i, .vis_o, .mem_ext_o, .src_row_o, .src_line_o
  );

  function automatic logic [10:0] model(int r, int l, logic [24:0] dh,
                                        logic d, logic b, logic s, logic e, logic k);
    logic up[25], ct[25];
    int sr = 0, sl = 0, base, x, y;
    logic vis = 1, ext;
    for (int i = 0; i < 25; i++) begin
      ct[i] = (i > 0 && i < 24) ? up[i-1] : 1'b0;
      up[i] = (i < 24) ? (dh[i] & ~ct[i]) : 1'b0;
    end
    if (r > 24 || l > 9) return '0;
    if (!d) begin
      sr = r;
      if (ct[r]) begin sr = r - 1; sl = (10 + l) / 2; end
      else if (up[r]) sl = l / 2;
      else sl = l;
    end else begin
      base = b ? 12 : 0;
      x = base + r / 2;
      y = (r % 2) * 10 + l;
      if (!b && x > 11) vis = 0;
      else if (ct[x] && x - 1 >= base) begin sr = x - 1; sl = (y + 20) / 4; end
      else if (up[x]) begin sr = x; sl = y / 4; end
      else begin sr = x; sl = y / 2; end
    end
    if (s && r < 24) vis = 0;
    ext = vis && sr == 24 && e && !k;
    if (ext) sr = 0;
    if (!vis) return '0;
    return {vis, ext, 5'(sr), 4'(sl)};
  endfunction

  function automatic string tag_of(int r, int l, logic [24:0] dh);
    if (r > 24 || l > 9) return "R11";
    if (m_s) return "R8";
    if (m_e && r == 24) return m_k ? "R10" : "R9";
    if (m_d) return (dh != 0) ? "R7" : (m_b ? "R6" : "R5");
    return (dh != 0) ? "R4" : "R3";
  endfunction

  task automatic compare_pending();
    logic [10:0] act;
    act = {vis_o, mem_ext_o, src_row_o, src_line_o};
    if (pend) begin
      compared++;
      if (act !== exp_v) begin
        mismatched++;
        $display("FAIL %s: got vis=%0b ext=%0b row=%0d line=%0d expected vis=%0b ext=%0b row=%0d line=%0d",
                 exp_tag, act[10], act[9], act[8:4], act[3:0],
                 exp_v[10], exp_v[9], exp_v[8:4], exp_v[3:0]);
      end
    end
  endtask

  task automatic step(int r, int l, logic chk, string tag = "");
    @(negedge clk);
    compare_pending();
    field_start_i = 1'b0;
    disp_row_i = 5'(r);
    scan_line_i = 4'(l);
    pend = chk;
    exp_v = model(r, l, row_dh_i, m_d, m_b, m_s, m_e, m_k);
    exp_tag = (tag == "") ? tag_of(r, l, row_dh_i) : tag;
  endtask

  task automatic new_field(logic d, logic b, logic s, logic e, logic k);
    @(negedge clk);
    compare_pending();
    pend = 1'b0;
    {dbl_mode_i, bottom_sel_i, status_only_i, row24_ext_i, link_back_i} = {d, b, s, e, k};
    field_start_i = 1'b1;
    {m_d, m_b, m_s, m_e, m_k} = {d, b, s, e, k};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [24:0] pats[3];
    pats[0] = '0;
    pats[1] = (25'd1 << 3) | (25'd1 << 4) | (25'd1 << 11) | (25'd1 << 23) | (25'd1 << 24);
    pats[2] = (25'd1 << 0) | (25'd1 << 12) | (25'd1 << 13) | (25'd1 << 14);

    // R1: reset state
    repeat (3) @(negedge clk);
    compared++;
    if ({vis_o, mem_ext_o, src_row_o, src_line_o} !== 11'd0) begin
      mismatched++;
      $display("FAIL R1: got %0h expected 0", {vis_o, mem_ext_o, src_row_o, src_line_o});
    end
    @(negedge clk);
    rst_ni = 1'b1;

    for (int p = 0; p < 3; p++) begin
      row_dh_i = pats[p];
      for (int c = 0; c < 32; c++) begin
        new_field(c[4], c[3], c[2], c[1], c[0]);
        for (int r = 0; r < 27; r++)
          for (int l = 0; l < 11; l++)
            step(r, l, 1'b1);
      end
    end

    // R2: config changed without field strobe has no effect
    row_dh_i = '0;
    new_field(0, 0, 0, 0, 0);
    step(0, 0, 1'b0);
    @(negedge clk);
    compare_pending();
    pend = 1'b0;
    {dbl_mode_i, bottom_sel_i, status_only_i, row24_ext_i, link_back_i} = 5'b11110;
    for (int r = 0; r < 25; r++) step(r, 7, 1'b1, "R2");
    // R2: applied once strobed
    new_field(1, 1, 1, 1, 0);
    step(24, 3, 1'b1, "R2");
    step(10, 3, 1'b1, "R2");
    // R1: one-cycle latency on back-to-back positions
    new_field(0, 0, 0, 0, 0);
    for (int r = 0; r < 25; r += 6) step(r, r % 10, 1'b1, "R1");
    @(negedge clk);
    compare_pending();
    pend = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule